// File: doc/BRIEF.md
# Per-Locality Interrupt Controller

This block keeps interrupt masking and pending state for each of several localities and drives one shared, level-type interrupt line. Event pulses arrive with a locality tag and a four-bit source vector: data available, status valid, locality changed and command ready. Each locality has an enable word and a pending-status word. An event is recorded only if the tagged locality has both its master enable and the enable for that source set. The line rises in the same clock edge that records the event.

A simple register port lets the locality that currently owns the interface program its enable word and clear its pending bits by writing ones. Writes from any other locality are dropped. Reads are combinational and may come from any locality. Two constant words are also readable. One lists the sources this block supports together with low-level line support. The other is a fixed vector number of four bits, set by a parameter.

Top module: `loc_irq_ctrl`

## Requirements
- R1: After reset every locality's enable word reads 0x00000008 (low-level polarity, bit 3), every status word reads 0, and `irq_o` is 0.
- R2: A write to the enable word (offset 0) from the owning locality stores the written value ANDed with 0x8000009F: bit 31 is the master enable, bits 4:3 are polarity, and source enables are bit 0 data available, bit 1 status valid, bit 2 locality changed, bit 7 command ready.
- R3: Writes to the enable word or the status word (offset 2) are ignored when `act_vld` is 0 or `bus_loc` differs from `act_loc`.
- R4: An event sets, in the tagged locality's status word, those bits of the source vector that are enabled there. `evt_src[0]` maps to bit 0, `evt_src[1]` to bit 1, `evt_src[2]` to bit 2 and `evt_src[3]` to bit 7. Nothing is set if bit 31 of that locality's enable word is clear. When at least one bit is set, `irq_o` is 1 after that clock edge.
- R5: Events tagged with a locality of 5 or above change neither any status word nor `irq_o`.
- R6: A status write from the owner clears exactly the written one-bits that fall within 0x87; all other status bits are kept.
- R7: `irq_o` falls after a status write that clears at least one set bit and leaves the writing locality's status at zero, even if another locality still holds pending bits. A clear that leaves bits set keeps `irq_o` high.
- R8: Offset 3 reads 0x00000097 (bit 4 low-level support plus the source bits); writes to it have no effect.
- R9: Offset 1 reads the vector parameter `IRQ_NUM` (0 to 15) in bits 3:0; writes to it have no effect.
- R10: When an event recording a bit and a clearing status write happen in the same cycle, the recorded bit survives and `irq_o` is 1.
- R11: Reads at offsets 4 to 7 return 0. Reads of the enable or status word with `bus_loc` of 5 or above return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_vld | input | 1 | A locality currently owns the interface |
| act_loc | input | 3 | Owning locality |
| bus_wr | input | 1 | Register write strobe |
| bus_loc | input | 3 | Locality of the access |
| bus_addr | input | 3 | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| evt_vld | input | 1 | Event strobe |
| evt_loc | input | 3 | Locality tag of the event |
| evt_src | input | 4 | Source vector of the event |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench builds the block with five localities and a vector number of 11. With that setting the vector register is checked against a value other than the default. Every tag from 0 to 7 can also be driven, so the dropped tags 5 and 7 are reachable. The behavioural model follows the line on every clock. The directed reads cover the ordering cases: clears that leave bits set, a clear across localities, and an event that coincides with a clear.

// File: rtl/loc_irq_ctrl.sv
module loc_irq_ctrl #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = 3,
  parameter int ADDR_W = 3,
  parameter logic [3:0] IRQ_NUM = 4'd5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_vld,
  input  logic [LOC_W-1:0]  act_loc,
  input  logic              bus_wr,
  input  logic [LOC_W-1:0]  bus_loc,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              evt_vld,
  input  logic [LOC_W-1:0]  evt_loc,
  input  logic [3:0]        evt_src,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] OFS_EN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_VEC  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_CAP  = ADDR_W'(3);
  localparam logic [31:0] SRC_MASK = 32'h0000_0087;
  localparam logic [31:0] EN_MASK  = 32'h8000_0018 | SRC_MASK;
  localparam logic [31:0] CAP_VAL  = 32'h0000_0010 | SRC_MASK;
  localparam logic [31:0] EN_RST   = 32'h0000_0008;
  localparam logic [LOC_W:0] NLOC  = NUM_LOC[LOC_W:0];

  logic [NUM_LOC-1:0][31:0] en_q, sts_q, hit, after_clr;
  logic [NUM_LOC-1:0]       raise_v, drop_v;
  logic                     irq_q;

  wire        bus_loc_ok = {1'b0, bus_loc} < NLOC;
  wire        owner      = act_vld && (bus_loc == act_loc) && bus_loc_ok;
  wire        wr_en      = bus_wr && owner && (bus_addr == OFS_EN);
  wire        wr_clr     = bus_wr && owner && (bus_addr == OFS_STAT);
  wire        evt_ok     = evt_vld && ({1'b0, evt_loc} < NLOC);
  wire [31:0] evt_bits   = {24'b0, evt_src[3], 4'b0, evt_src[2:0]};
  wire [31:0] clr_bits   = bus_wdata & SRC_MASK;

  always_comb begin
    for (int k = 0; k < NUM_LOC; k++) begin
      hit[k] = (evt_ok && evt_loc == LOC_W'(k) && en_q[k][31]) ? (evt_bits & en_q[k]) : 32'b0;
      after_clr[k] = (wr_clr && bus_loc == LOC_W'(k)) ? (sts_q[k] & ~clr_bits) : sts_q[k];
      raise_v[k] = |hit[k];
      drop_v[k] = wr_clr && bus_loc == LOC_W'(k) && |clr_bits && |sts_q[k] && after_clr[k] == 32'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_LOC; k++) begin
        en_q[k]  <= EN_RST;
        sts_q[k] <= 32'b0;
      end
      irq_q <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_LOC; k++) begin
        if (wr_en && bus_loc == LOC_W'(k)) en_q[k] <= bus_wdata & EN_MASK;
        sts_q[k] <= after_clr[k] | hit[k];
      end
      if (|raise_v)     irq_q <= 1'b1;
      else if (|drop_v) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  always_comb begin
    bus_rdata = 32'b0;
    case (bus_addr)
      OFS_EN:   if (bus_loc_ok) bus_rdata = en_q[bus_loc];
      OFS_STAT: if (bus_loc_ok) bus_rdata = sts_q[bus_loc];
      OFS_VEC:  bus_rdata = {28'b0, IRQ_NUM};
      OFS_CAP:  bus_rdata = CAP_VAL;
      default:  bus_rdata = 32'b0;
    endcase
  end

endmodule

// File: rtl/loc_irq_ctrl_chk.sv
module loc_irq_ctrl_chk #(
  parameter int NUM_LOC = 5,
  parameter int LOC_W = 3,
  parameter int ADDR_W = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     act_vld,
  input logic [LOC_W-1:0]         act_loc,
  input logic                     bus_wr,
  input logic [LOC_W-1:0]         bus_loc,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     evt_vld,
  input logic [LOC_W-1:0]         evt_loc,
  input logic                     irq_o,
  input logic [NUM_LOC-1:0][31:0] en_q,
  input logic [NUM_LOC-1:0][31:0] sts_q
);
  localparam logic [LOC_W:0] NLOC = NUM_LOC[LOC_W:0];

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(evt_vld)); // R4

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(bus_wr && bus_addr == ADDR_W'(2))); // R7

  AST_BAD_TAG_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vld && {1'b0, evt_loc} >= NLOC && !bus_wr) |=> $stable(irq_o)); // R5

  for (genvar k = 0; k < NUM_LOC; k++) begin : g_loc
    AST_EN_OWNER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!(bus_wr && bus_addr == ADDR_W'(0) && act_vld && act_loc == LOC_W'(k) && bus_loc == LOC_W'(k)))
      |=> $stable(en_q[k])); // R3

    AST_STS_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(evt_vld && evt_loc == LOC_W'(k) && en_q[k][31]))
      |=> ((sts_q[k] | $past(sts_q[k])) == $past(sts_q[k]))); // R4
  end
endmodule

bind loc_irq_ctrl loc_irq_ctrl_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/loc_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module loc_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_vld = 1'b0;
  logic [2:0]  act_loc = 3'd0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_loc = 3'd0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        evt_vld = 1'b0;
  logic [2:0]  evt_loc = 3'd0;
  logic [3:0]  evt_src = 4'd0;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  loc_irq_ctrl #(.NUM_LOC(5), .LOC_W(3), .ADDR_W(3), .IRQ_NUM(4'd11)) dut_i (
    .clk(clk), .rst_n(rst_n), .act_vld(act_vld), .act_loc(act_loc),
    .bus_wr(bus_wr), .bus_loc(bus_loc), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .evt_vld(evt_vld), .evt_loc(evt_loc), .evt_src(evt_src),
    .irq_o(irq_o));

  // behavioural reference model
  logic [31:0] m_en [0:4];
  logic [31:0] m_sts [0:4];
  logic        m_irq;
  logic [31:0] mb, mhit, mold, mclr;
  bit          mraise, mdrop, mown;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) begin m_en[k] = 32'h8; m_sts[k] = 32'h0; end
      m_irq = 1'b0;
    end else begin
      mraise = 0; mdrop = 0; mhit = 0;
      mb = (evt_src[0] ? 32'h1 : 0) | (evt_src[1] ? 32'h2 : 0) |
           (evt_src[2] ? 32'h4 : 0) | (evt_src[3] ? 32'h80 : 0);
      if (evt_vld && evt_loc < 5) begin
        if (m_en[evt_loc][31]) mhit = mb & m_en[evt_loc];
      end
      mown = act_vld && bus_loc == act_loc && bus_loc < 5;
      if (bus_wr && mown && bus_addr == 3'd2) begin
        mold = m_sts[bus_loc];
        mclr = bus_wdata & 32'h87;
        m_sts[bus_loc] = mold & ~mclr;
        if (mclr != 0 && mold != 0 && m_sts[bus_loc] == 0) mdrop = 1;
      end
      if (mhit != 0) begin m_sts[evt_loc] = m_sts[evt_loc] | mhit; mraise = 1; end
      if (bus_wr && mown && bus_addr == 3'd0) m_en[bus_loc] = bus_wdata & 32'h8000009F;
      if (mraise) m_irq = 1'b1;
      else if (mdrop) m_irq = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq_o !== m_irq) begin
        errors++;
        $display("FAIL R4 R7 model line: act=%0b exp=%0b", irq_o, m_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [2:0] l, input logic [2:0] a, input logic [31:0] d,
                      input bit ev, input logic [2:0] el, input logic [3:0] es);
    @(negedge clk);
    bus_wr = wr; bus_loc = l; bus_addr = a; bus_wdata = d;
    evt_vld = ev; evt_loc = el; evt_src = es;
  endtask

  task automatic wr(input logic [2:0] l, input logic [2:0] a, input logic [31:0] d);
    step(1'b1, l, a, d, 1'b0, 3'd0, 4'd0);
  endtask

  task automatic ev(input logic [2:0] el, input logic [3:0] es);
    step(1'b0, 3'd0, 3'd0, 32'd0, 1'b1, el, es);
  endtask

  task automatic rd(input string req, input logic [2:0] l, input logic [2:0] a, input logic [31:0] exp);
    step(1'b0, l, a, 32'd0, 1'b0, 3'd0, 4'd0);
    #1;
    chk(req, bus_rdata, exp);
  endtask

  task automatic line(input string req, input logic exp);
    #1;
    chk(req, {31'b0, irq_o}, {31'b0, exp});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    for (int k = 0; k < 5; k++) begin
      rd("R1 enable reset", 3'(k), 3'd0, 32'h8);
      rd("R1 status reset", 3'(k), 3'd2, 32'h0);
    end
    line("R1 line reset", 1'b0);
    // R8, R9, R11
    act_vld = 1'b1; act_loc = 3'd0;
    rd("R8 capability", 3'd0, 3'd3, 32'h97);
    wr(3'd0, 3'd3, 32'h0);
    rd("R8 capability after write", 3'd0, 3'd3, 32'h97);
    rd("R9 vector", 3'd0, 3'd1, 32'd11);
    wr(3'd0, 3'd1, 32'h3);
    rd("R9 vector after write", 3'd0, 3'd1, 32'd11);
    rd("R11 unmapped offset", 3'd0, 3'd5, 32'h0);
    rd("R11 bad locality read", 3'd6, 3'd0, 32'h0);
    // R3 enable guard
    act_vld = 1'b0;
    wr(3'd1, 3'd0, 32'hFFFF_FFFF);
    rd("R3 no owner", 3'd1, 3'd0, 32'h8);
    act_vld = 1'b1; act_loc = 3'd0;
    wr(3'd1, 3'd0, 32'hFFFF_FFFF);
    rd("R3 other owner", 3'd1, 3'd0, 32'h8);
    // R2
    act_loc = 3'd1;
    wr(3'd1, 3'd0, 32'hFFFF_FFFF);
    rd("R2 masked enable", 3'd1, 3'd0, 32'h8000_009F);
    // R4 latch
    ev(3'd1, 4'hF);
    rd("R4 latched bits", 3'd1, 3'd2, 32'h87);
    line("R4 line up", 1'b1);
    // R6
    wr(3'd1, 3'd2, 32'hFFFF_FF78);
    rd("R6 unsupported clear", 3'd1, 3'd2, 32'h87);
    wr(3'd1, 3'd2, 32'h1);
    rd("R6 partial clear", 3'd1, 3'd2, 32'h86);
    line("R7 line held", 1'b1);
    wr(3'd1, 3'd2, 32'hFFFF_FFFF);
    rd("R7 full clear", 3'd1, 3'd2, 32'h0);
    line("R7 line down", 1'b0);
    // R4 disabled cases
    ev(3'd2, 4'hF);
    rd("R4 locality disabled", 3'd2, 3'd2, 32'h0);
    line("R4 line stays low", 1'b0);
    wr(3'd1, 3'd0, 32'h0000_0087);
    ev(3'd1, 4'hF);
    rd("R4 master enable off", 3'd1, 3'd2, 32'h0);
    line("R4 no line without master", 1'b0);
    // R5
    ev(3'd5, 4'hF);
    ev(3'd7, 4'hF);
    line("R5 bad tag", 1'b0);
    for (int k = 0; k < 5; k++) rd("R5 no status", 3'(k), 3'd2, 32'h0);
    // R4 partial sources
    wr(3'd1, 3'd0, 32'h8000_0004);
    ev(3'd1, 4'hF);
    rd("R4 source filter", 3'd1, 3'd2, 32'h4);
    line("R4 line up again", 1'b1);
    // R3 status guard
    act_loc = 3'd0;
    wr(3'd1, 3'd2, 32'hFFFF_FFFF);
    rd("R3 status guard", 3'd1, 3'd2, 32'h4);
    line("R3 line unchanged", 1'b1);
    // R7 cross locality
    act_loc = 3'd2;
    wr(3'd2, 3'd0, 32'h8000_0080);
    ev(3'd2, 4'b1000);
    rd("R4 command ready bit", 3'd2, 3'd2, 32'h80);
    wr(3'd2, 3'd2, 32'h80);
    rd("R7 writer cleared", 3'd2, 3'd2, 32'h0);
    line("R7 drops with other pending", 1'b0);
    rd("R7 other kept", 3'd1, 3'd2, 32'h4);
    // R10
    act_loc = 3'd1;
    step(1'b1, 3'd1, 3'd2, 32'h4, 1'b1, 3'd1, 4'b0100);
    rd("R10 set beats clear", 3'd1, 3'd2, 32'h4);
    line("R10 line up", 1'b1);
    wr(3'd1, 3'd2, 32'h4);
    rd("R10 later clear", 3'd1, 3'd2, 32'h0);
    line("R7 line down again", 1'b0);
    step(1'b0, 3'd0, 3'd0, 32'd0, 1'b0, 3'd0, 4'd0);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule